// File: doc/BRIEF.md
# Boot Path Selector with Code-Space ROM Overlay

This block chooses where the processor starts running after a hardware reset. It also controls whether a 2K-byte boot ROM covers the top of the 64K code space. In the first clock cycle after reset is released, it takes one sample of three reset-time strap pins and three non-volatile configuration values:

- a skip-boot fuse bit
- a boot status byte
- a software boot vector byte

It turns these into a start address, which it presents with a one-cycle valid strobe, and into the initial state of the overlay enable.

After that first cycle, software owns the overlay enable. It is a single bit inside a special-function register and is changed by ordinary register writes. Software sets the bit before calling the service entry point at FFF0h and clears it afterwards. The code-fetch decode sends each fetch to the ROM or to the flash. With the overlay off, all 64K bytes of flash are visible.

Top module: `boot_start_sel`

## Requirements
- R1: While reset is asserted, `start_valid` is 0, `start_pc` is 0000h and `overlay_en` is 0.
- R2: `start_valid` is high for exactly one cycle. That cycle is the first clock edge after reset is released. The strobe does not appear again until the next reset.
- R3: The strap condition is `strap_fetch_n`=0, `strap_extmem`=1 and `strap_latch`=1, all sampled together. When it holds, the start address is F800h and `overlay_en` becomes 1, whatever the configuration values are. If any one of the three pins differs, the strap condition is absent.
- R4: With the strap condition absent and `cfg_skip_boot`=1, the start address is 0000h and `overlay_en` stays 0.
- R5: With the strap condition absent, `cfg_skip_boot`=0 and `cfg_status`=00h, the start address is 0000h and `overlay_en` stays 0.
- R6: With the strap condition absent, `cfg_skip_boot`=0, `cfg_status`≠00h and `cfg_vector`=FCh, the start address is F800h and `overlay_en` becomes 1.
- R7: In the same situation with any other vector value V, the start address is {V, 00h} and `overlay_en` stays 0. This includes V=F8h, which gives F800h with the overlay off.
- R8: After the start cycle, a write with `sfr_addr`=A2h loads `overlay_en` from data bit 5. The other data bits have no effect. A write to any other address leaves `overlay_en` unchanged.
- R9: `fetch_rom` is 1 exactly when `overlay_en`=1 and `fetch_addr` is in F800h..FFFFh. Otherwise the fetch goes to flash, including F800h..FFFFh while the overlay is off.
- R10: Strap and configuration inputs are sampled only once. Changing them after the start cycle alters neither `start_pc` nor `overlay_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| strap_fetch_n | input | 1 | Program-fetch strobe pin level at reset end (active low) |
| strap_extmem | input | 1 | External-memory select pin level at reset end |
| strap_latch | input | 1 | Address-latch pin level at reset end |
| cfg_skip_boot | input | 1 | Non-volatile skip-boot fuse bit |
| cfg_status | input | 8 | Non-volatile boot status byte |
| cfg_vector | input | 8 | Non-volatile software boot vector (high address byte) |
| sfr_wr | input | 1 | Special-function register write strobe |
| sfr_addr | input | 8 | Special-function register address |
| sfr_wdata | input | 8 | Special-function register write data |
| fetch_addr | input | 16 | Code-fetch address |
| fetch_rom | output | 1 | 1: fetch served by boot ROM, 0: by flash |
| overlay_en | output | 1 | Current overlay enable bit |
| start_pc | output | 16 | Chosen start address |
| start_valid | output | 1 | One-cycle strobe qualifying `start_pc` |

## Verification
A wrong decision state shows up one clock edge after reset release. In that cycle `start_pc` or `overlay_en` disagrees with the priority chain while `start_valid` is high. A stale or corrupted overlay bit appears at `fetch_rom` in the same cycle as the fetch address that crosses F7FFh/F800h. A sample flag that fails to stick shows up as a second strobe, or a changed start address, one edge after the configuration inputs move.

// File: rtl/boot_start_sel.sv
module boot_start_sel #(
  parameter int ADDR_W = 16,
  parameter int ROM_AW = 11,
  parameter int DATA_W = 8,
  parameter int SFR_AW = 8,
  parameter logic [SFR_AW-1:0] SFR_ADDR = 8'hA2,
  parameter int OVL_BIT = 5,
  parameter logic [DATA_W-1:0] ROM_VEC_CODE = 8'hFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_fetch_n,
  input  logic              strap_extmem,
  input  logic              strap_latch,
  input  logic              cfg_skip_boot,
  input  logic [DATA_W-1:0] cfg_status,
  input  logic [DATA_W-1:0] cfg_vector,
  input  logic              sfr_wr,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_rom,
  output logic              overlay_en,
  output logic [ADDR_W-1:0] start_pc,
  output logic              start_valid
);
  localparam int HI_W = ADDR_W - ROM_AW;
  localparam int LO_W = ADDR_W - DATA_W;
  localparam logic [ADDR_W-1:0] ROM_BASE = {{HI_W{1'b1}}, {ROM_AW{1'b0}}};

  logic              sampled;
  logic              strap_boot;
  logic              sfr_hit;
  logic [ADDR_W-1:0] pc_nxt;
  logic              ovl_nxt;
  logic              unused_wdata;

  assign strap_boot   = !strap_fetch_n && strap_extmem && strap_latch;
  assign sfr_hit      = sfr_wr && (sfr_addr == SFR_ADDR);
  assign fetch_rom    = overlay_en && (&fetch_addr[ADDR_W-1:ROM_AW]);
  assign unused_wdata = ^sfr_wdata;

  always_comb begin
    pc_nxt  = '0;
    ovl_nxt = 1'b0;
    if (strap_boot) begin
      pc_nxt  = ROM_BASE;
      ovl_nxt = 1'b1;
    end else if (cfg_skip_boot || (cfg_status == '0)) begin
      pc_nxt  = '0;
    end else if (cfg_vector == ROM_VEC_CODE) begin
      pc_nxt  = ROM_BASE;
      ovl_nxt = 1'b1;
    end else begin
      pc_nxt  = {cfg_vector, {LO_W{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sampled     <= 1'b0;
      start_valid <= 1'b0;
      start_pc    <= '0;
      overlay_en  <= 1'b0;
    end else if (!sampled) begin
      sampled     <= 1'b1;
      start_valid <= 1'b1;
      start_pc    <= pc_nxt;
      overlay_en  <= ovl_nxt;
    end else begin
      start_valid <= 1'b0;
      if (sfr_hit) overlay_en <= sfr_wdata[OVL_BIT];
    end
  end

  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |=> !start_valid);

  p_no_late_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sampled && !start_valid) |=> !start_valid);

  p_rom_start_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && overlay_en) |-> (start_pc == ROM_BASE));

  p_sfr_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sampled && sfr_hit) |=> (overlay_en == $past(sfr_wdata[OVL_BIT])));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sampled && !sfr_hit) |=> ($stable(overlay_en) && $stable(start_pc)));

  p_flash_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !overlay_en |-> !fetch_rom);
endmodule

// File: tb/tb_boot_start_sel.sv
module tb_boot_start_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_fetch_n = 1'b1, strap_extmem = 1'b0, strap_latch = 1'b0;
  logic        cfg_skip_boot = 1'b1;
  logic [7:0]  cfg_status = 8'hFF, cfg_vector = 8'hFC;
  logic        sfr_wr = 1'b0;
  logic [7:0]  sfr_addr = 8'h00, sfr_wdata = 8'h00;
  logic [15:0] fetch_addr = 16'h0000;
  logic        fetch_rom, overlay_en, start_valid;
  logic [15:0] start_pc;
  int nvec = 0, nbad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  boot_start_sel dut (
    .clk(clk), .rst_n(rst_n),
    .strap_fetch_n(strap_fetch_n), .strap_extmem(strap_extmem), .strap_latch(strap_latch),
    .cfg_skip_boot(cfg_skip_boot), .cfg_status(cfg_status), .cfg_vector(cfg_vector),
    .sfr_wr(sfr_wr), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .fetch_addr(fetch_addr), .fetch_rom(fetch_rom), .overlay_en(overlay_en),
    .start_pc(start_pc), .start_valid(start_valid));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic boot(input logic fn, ex, al, sk, input logic [7:0] st, vc,
                      input logic [15:0] exp_pc, input logic exp_ovl, input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    strap_fetch_n = fn; strap_extmem = ex; strap_latch = al;
    cfg_skip_boot = sk; cfg_status = st; cfg_vector = vc;
    repeat (2) @(negedge clk);
    chk({tag, " R1 reset valid"}, start_valid, 0);
    chk({tag, " R1 reset pc"}, start_pc, 0);
    chk({tag, " R1 reset ovl"}, overlay_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({tag, " R2 strobe"}, start_valid, 1);
    chk({tag, " pc"}, start_pc, exp_pc);
    chk({tag, " ovl"}, overlay_en, exp_ovl);
    @(negedge clk);
    chk({tag, " R2 strobe low"}, start_valid, 0);
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic test_chain;
    boot(0, 1, 1, 1, 8'hFF, 8'h12, 16'hF800, 1, "R3 strap");
    boot(0, 1, 0, 1, 8'hFF, 8'hFC, 16'h0000, 0, "R3 partial strap, R4");
    boot(1, 0, 0, 1, 8'h00, 8'hFC, 16'h0000, 0, "R4 skip");
    boot(1, 1, 1, 0, 8'h00, 8'hFC, 16'h0000, 0, "R5 status zero");
    boot(1, 0, 1, 0, 8'h5A, 8'hFC, 16'hF800, 1, "R6 vector rom");
    boot(1, 0, 0, 0, 8'h01, 8'h3C, 16'h3C00, 0, "R7 vector user");
    boot(1, 0, 0, 0, 8'hFF, 8'hF8, 16'hF800, 0, "R7 vector F8");
    boot(1, 0, 0, 0, 8'hFF, 8'h00, 16'h0000, 0, "R7 vector 00");
  endtask

  task automatic test_sfr;
    boot(1, 0, 0, 1, 8'hFF, 8'h00, 16'h0000, 0, "R8 setup");
    sfr_write(8'hA2, 8'h20);
    chk("R8 set", overlay_en, 1);
    sfr_write(8'hA3, 8'h00);
    chk("R8 other addr", overlay_en, 1);
    sfr_write(8'hA2, 8'hDF);
    chk("R8 clear other bits set", overlay_en, 0);
    sfr_write(8'h22, 8'hFF);
    chk("R8 other addr keep 0", overlay_en, 0);
    sfr_write(8'hA2, 8'h20);
    chk("R8 set again", overlay_en, 1);
  endtask

  task automatic test_fetch;
    logic [15:0] addrs [5] = '{16'h0000, 16'hF7FF, 16'hF800, 16'hFFF0, 16'hFFFF};
    logic        exp_on [5] = '{0, 0, 1, 1, 1};
    sfr_write(8'hA2, 8'h20);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); fetch_addr = addrs[i]; #1;
      chk($sformatf("R9 ovl on %04h", addrs[i]), fetch_rom, exp_on[i]);
    end
    sfr_write(8'hA2, 8'h00);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); fetch_addr = addrs[i]; #1;
      chk($sformatf("R9 ovl off %04h", addrs[i]), fetch_rom, 0);
    end
  endtask

  task automatic test_once;
    boot(0, 1, 1, 0, 8'h00, 8'h00, 16'hF800, 1, "R10 setup");
    @(negedge clk);
    strap_fetch_n = 1; strap_extmem = 0; strap_latch = 0;
    cfg_skip_boot = 0; cfg_status = 8'h44; cfg_vector = 8'h21;
    repeat (4) @(negedge clk);
    chk("R10 no strobe", start_valid, 0);
    chk("R10 pc kept", start_pc, 16'hF800);
    chk("R10 ovl kept", overlay_en, 1);
  endtask

  initial begin
    test_chain();
    test_sfr();
    test_fetch();
    test_once();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nvec++; nbad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule